// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits in front of a processor core and decides, at each instruction boundary the core reports, whether to enter a non-maskable interrupt (NMI) or a maskable interrupt, or to enter neither. It keeps the interrupt-enable flag, one saved copy of that flag, an NMI-in-service bit and a single pending-NMI latch. When it decides to enter, it gives the core a one-cycle take strobe together with an 8-bit vector and a flag that tells NMI entries from maskable ones.

An NMI is edge-detected through a synchronizer. It is dispatched with the fixed vector 2 and no external cycle. A maskable request is a level. It obtains its vector from outside through a request/valid acknowledge handshake. The block raises `ack_req_o` and holds it until the responder presents `ack_vld_i`, so the responder can apply back-pressure by delaying `ack_vld_i` for as long as it needs. A valid while no request is up is ignored. Instruction boundaries that arrive while an acknowledge is outstanding are not sampled.

An interrupt-return pulse restores the enable flag from the saved copy and ends NMI service. Software writes to the flag let a handler re-enable maskable interrupts so that they nest.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `take_o`, `ack_req_o`, `ie_o` and `nmi_active_o` are 0, and no NMI is pending.
- R2: At a sampled boundary where an NMI is pending and none is in service, the cycle after the boundary shows `take_o`=1, `take_nmi_o`=1 and `take_vec_o`=2. `ack_req_o` stays 0 and `nmi_active_o` becomes 1.
- R3: At a sampled boundary with `intr_i`=1 and the enable flag set (and no NMI entry), `ack_req_o` rises the next cycle and holds until `ack_vld_i`. The cycle after that handshake shows `take_o`=1, `take_nmi_o`=0 and `take_vec_o` equal to `ack_vec_i` as it was at the handshake.
- R4: Either kind of entry clears `ie_o` in the same cycle that the take strobe (for an NMI) or `ack_req_o` (for a maskable request) first appears.
- R5: `intr_i` is ignored while the enable flag is 0. Boundaries are not sampled while `ack_req_o` is 1.
- R6: When an NMI and a maskable request are both eligible at one boundary, the NMI is entered.
- R7: While `nmi_active_o`=1 no NMI is entered. One NMI edge seen during service is kept and entered at the first boundary after the interrupt-return. Further edges in that time are lost.
- R8: An `iret_i` pulse loads the enable flag from the copy saved at the last entry and clears `nmi_active_o`.
- R9: `ie_wr_i` loads `ie_wdata_i` into the enable flag, so a handler can re-enable and take a nested maskable interrupt.
- R10: An NMI level that stays high counts as one request. A rise that is first sampled at clock edge k can be entered at a boundary sampled at edge k+3 or later, and not before.
- R11: In one cycle, an entry takes precedence over `iret_i` and `ie_wr_i` (both are then ignored), and `iret_i` takes precedence over `ie_wr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_i | input | 1 | Maskable request level |
| nmi_i | input | 1 | Asynchronous NMI input, rising edge requests |
| boundary_i | input | 1 | One-cycle pulse at an instruction boundary |
| iret_i | input | 1 | One-cycle pulse when an interrupt-return retires |
| ie_wr_i | input | 1 | Software write strobe for the enable flag |
| ie_wdata_i | input | 1 | Value written to the enable flag |
| ack_req_o | output | 1 | Acknowledge request, held until answered |
| ack_vld_i | input | 1 | Responder presents the vector |
| ack_vec_i | input | 8 | Vector supplied with `ack_vld_i` |
| take_o | output | 1 | One-cycle entry strobe |
| take_vec_o | output | 8 | Vector of the latest entry |
| take_nmi_o | output | 1 | 1 if the latest entry is an NMI |
| ie_o | output | 1 | Current interrupt-enable flag |
| nmi_active_o | output | 1 | NMI service in progress |

## Verification
The checker assumes that `ack_vld_i` carries meaning only while `ack_req_o` is up. It also assumes that `boundary_i` and `iret_i` are single-cycle pulses driven synchronously to `clk`. The stimulus raises `ack_vld_i` only in cycles where it sees `ack_req_o` high, and it drives every input at the falling edge. The randomized phase also lets `iret_i` land with no handler open and in the same cycle as entries and writes. The reference model covers those collisions through the precedence order of R11, so no assertion depends on `iret_i` being matched to an entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [0:0] {
    ACK_IDLE = 1'b0,
    ACK_WAIT = 1'b1
  } ack_state_e;

  typedef struct packed {
    logic enter_nmi;
    logic enter_intr;
  } entry_sel_t;
endpackage

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  output logic nmi_rise_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= nmi_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // rise seen between the last synchronized stage and its delayed copy
  assign nmi_rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/irq_ack_port.sv
module irq_ack_port
  import irq_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_vld_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic             ack_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [VEC_W-1:0] vec_o
);
  ack_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE: if (start_i)   state_d = ACK_WAIT;
      ACK_WAIT: if (ack_vld_i) state_d = ACK_IDLE;
      default:                 state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACK_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o    = (state_q == ACK_WAIT);
  assign ack_req_o = busy_o;
  assign done_o    = busy_o & ack_vld_i;
  assign vec_o     = ack_vec_i;
endmodule

// File: rtl/irq_flag_keeper.sv
module irq_flag_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_rise_i,
  input  logic enter_nmi_i,
  input  logic enter_intr_i,
  input  logic iret_i,
  input  logic ie_wr_i,
  input  logic ie_wdata_i,
  output logic ie_o,
  output logic nmi_active_o,
  output logic nmi_pend_o
);
  logic ie_q, ie_saved_q, active_q, pend_q;
  logic entry;

  assign entry = enter_nmi_i | enter_intr_i;

  // enable flag: entry > return > software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      ie_saved_q <= 1'b0;
    end else if (entry) begin
      ie_q       <= 1'b0;
      ie_saved_q <= ie_q;
    end else if (iret_i) begin
      ie_q       <= ie_saved_q;
    end else if (ie_wr_i) begin
      ie_q       <= ie_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 active_q <= 1'b0;
    else if (enter_nmi_i)       active_q <= 1'b1;
    else if (iret_i && !entry)  active_q <= 1'b0;
  end

  // single pending slot; a rise coinciding with entry refills it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend_q <= 1'b0;
    else if (enter_nmi_i) pend_q <= nmi_rise_i;
    else if (nmi_rise_i)  pend_q <= 1'b1;
  end

  assign ie_o         = ie_q;
  assign nmi_active_o = active_q;
  assign nmi_pend_o   = pend_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int NMI_VEC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intr_i,
  input  logic             nmi_i,
  input  logic             boundary_i,
  input  logic             iret_i,
  input  logic             ie_wr_i,
  input  logic             ie_wdata_i,
  output logic             ack_req_o,
  input  logic             ack_vld_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic             take_o,
  output logic [VEC_W-1:0] take_vec_o,
  output logic             take_nmi_o,
  output logic             ie_o,
  output logic             nmi_active_o
);
  localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

  logic             nmi_rise, nmi_pend;
  logic             ack_busy, ack_done;
  logic [VEC_W-1:0] ack_vec;
  logic             sample;
  entry_sel_t       sel;

  irq_nmi_detect #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_i      (nmi_i),
    .nmi_rise_o (nmi_rise)
  );

  assign sample         = boundary_i & ~ack_busy;
  assign sel.enter_nmi  = sample & nmi_pend & ~nmi_active_o;
  assign sel.enter_intr = sample & ~sel.enter_nmi & intr_i & ie_o;

  irq_ack_port #(.VEC_W(VEC_W)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (sel.enter_intr),
    .ack_vld_i (ack_vld_i),
    .ack_vec_i (ack_vec_i),
    .ack_req_o (ack_req_o),
    .busy_o    (ack_busy),
    .done_o    (ack_done),
    .vec_o     (ack_vec)
  );

  irq_flag_keeper u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .nmi_rise_i   (nmi_rise),
    .enter_nmi_i  (sel.enter_nmi),
    .enter_intr_i (sel.enter_intr),
    .iret_i       (iret_i),
    .ie_wr_i      (ie_wr_i),
    .ie_wdata_i   (ie_wdata_i),
    .ie_o         (ie_o),
    .nmi_active_o (nmi_active_o),
    .nmi_pend_o   (nmi_pend)
  );

  // registered dispatch; NMI entry and handshake completion are exclusive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      take_vec_o <= '0;
      take_nmi_o <= 1'b0;
    end else begin
      take_o <= sel.enter_nmi | ack_done;
      if (sel.enter_nmi) begin
        take_vec_o <= NMI_CODE;
        take_nmi_o <= 1'b1;
      end else if (ack_done) begin
        take_vec_o <= ack_vec;
        take_nmi_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iret_i,
  input logic             ack_vld_i,
  input logic             ack_req_o,
  input logic             take_o,
  input logic [VEC_W-1:0] take_vec_o,
  input logic             take_nmi_o,
  input logic             ie_o,
  input logic             nmi_active_o
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!take_o && !ack_req_o && !ie_o && !nmi_active_o));

  assert_nmi_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_nmi_o) |-> (take_vec_o == VEC_W'(NMI_VEC) && nmi_active_o && !ack_req_o));

  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && !ack_vld_i) |=> ack_req_o);

  assert_ack_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && ack_vld_i) |=> (take_o && !take_nmi_o && !ack_req_o));

  assert_ie_clear_nmi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_nmi_o) |-> !ie_o);

  assert_ie_clear_intr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req_o) |-> !ie_o);

  assert_no_sample_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |=> !(take_o && take_nmi_o));

  assert_nmi_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_active_o && !iret_i) |=> !(take_o && take_nmi_o));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .iret_i       (iret_i),
  .ack_vld_i    (ack_vld_i),
  .ack_req_o    (ack_req_o),
  .take_o       (take_o),
  .take_vec_o   (take_vec_o),
  .take_nmi_o   (take_nmi_o),
  .ie_o         (ie_o),
  .nmi_active_o (nmi_active_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       intr_i = 1'b0, nmi_i = 1'b0, boundary_i = 1'b0, iret_i = 1'b0;
  logic       ie_wr_i = 1'b0, ie_wdata_i = 1'b0, ack_vld_i = 1'b0;
  logic [7:0] ack_vec_i = 8'h00;
  logic       ack_req_o, take_o, take_nmi_o, ie_o, nmi_active_o;
  logic [7:0] take_vec_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .intr_i(intr_i), .nmi_i(nmi_i),
    .boundary_i(boundary_i), .iret_i(iret_i), .ie_wr_i(ie_wr_i),
    .ie_wdata_i(ie_wdata_i), .ack_req_o(ack_req_o), .ack_vld_i(ack_vld_i),
    .ack_vec_i(ack_vec_i), .take_o(take_o), .take_vec_o(take_vec_o),
    .take_nmi_o(take_nmi_o), .ie_o(ie_o), .nmi_active_o(nmi_active_o)
  );

  // ---------------- behavioural reference ----------------
  bit nh[$] = '{0, 0, 0};   // NMI samples, newest first
  bit m_take = 0, m_tnmi = 0, m_ack = 0, m_ie = 0, m_sav = 0, m_act = 0, m_pend = 0;
  int m_vec = 0;

  always @(posedge clk) begin
    bit rise;
    bit can, e_nmi, e_int;
    rise = nh[1] && !nh[2];
    nh.push_front(nmi_i);
    void'(nh.pop_back());
    if (!rst_n) begin
      nh = '{0, 0, 0};
      m_take = 0; m_tnmi = 0; m_ack = 0; m_ie = 0; m_sav = 0;
      m_act = 0; m_pend = 0; m_vec = 0;
    end else begin
      m_take = 0;
      can   = boundary_i && !m_ack;
      e_nmi = can && m_pend && !m_act;
      e_int = can && !e_nmi && intr_i && m_ie;
      if (m_ack && ack_vld_i) begin
        m_take = 1; m_vec = ack_vec_i; m_tnmi = 0; m_ack = 0;
      end
      if (e_nmi) begin
        m_take = 1; m_vec = 2; m_tnmi = 1; m_act = 1;
        m_sav = m_ie; m_ie = 0; m_pend = rise;
      end else if (e_int) begin
        m_ack = 1; m_sav = m_ie; m_ie = 0;
        if (rise) m_pend = 1;
      end else begin
        if (rise) m_pend = 1;
        if (iret_i) begin m_ie = m_sav; m_act = 0; end
        else if (ie_wr_i) m_ie = ie_wdata_i;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      chk("R2/R3 take_o vs model", take_o, m_take);
      chk("R3 ack_req_o vs model", ack_req_o, m_ack);
      chk("R8/R9/R11 ie_o vs model", ie_o, m_ie);
      chk("R7 nmi_active_o vs model", nmi_active_o, m_act);
      if (take_o) begin
        chk("R2/R3 take_vec_o vs model", take_vec_o, m_vec);
        chk("R6 take_nmi_o vs model", take_nmi_o, m_tnmi);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic bnd(); boundary_i = 1; step(); boundary_i = 0; endtask
  task automatic nmi_pulse(); nmi_i = 1; step(); nmi_i = 0; step(); endtask
  task automatic do_iret(); iret_i = 1; step(); iret_i = 0; endtask
  task automatic wr_ie(input bit v); ie_wr_i = 1; ie_wdata_i = v; step(); ie_wr_i = 0; endtask

  initial begin
    repeat (3) step();
    chk("R1 take_o in reset", take_o, 0);
    chk("R1 ack_req_o in reset", ack_req_o, 0);
    chk("R1 ie_o in reset", ie_o, 0);
    chk("R1 nmi_active_o in reset", nmi_active_o, 0);
    rst_n = 1; step();
    bnd();
    chk("R1 no pending NMI after reset", take_o, 0);

    wr_ie(1);
    chk("R9 software write sets ie", ie_o, 1);
    intr_i = 1; bnd();
    chk("R3 ack request raised", ack_req_o, 1);
    chk("R4 ie cleared on maskable entry", ie_o, 0);
    step(); step();
    chk("R3 request held without valid", ack_req_o, 1);
    ack_vld_i = 1; ack_vec_i = 8'h41; step(); ack_vld_i = 0; intr_i = 0;
    chk("R3 take after handshake", take_o, 1);
    chk("R3 vector from responder", take_vec_o, 8'h41);
    chk("R3 type flag maskable", take_nmi_o, 0);
    chk("R3 request dropped", ack_req_o, 0);
    do_iret();
    chk("R8 return restores ie", ie_o, 1);

    wr_ie(0);
    intr_i = 1; bnd();
    chk("R5 intr ignored with ie clear", ack_req_o, 0);
    intr_i = 0;

    nmi_i = 1; step(); nmi_i = 0;
    step(); bnd();
    chk("R10 rise not eligible before third edge", take_o, 0);
    bnd();
    chk("R2 NMI take strobe", take_o, 1);
    chk("R2 NMI vector 2", take_vec_o, 2);
    chk("R2 NMI type flag", take_nmi_o, 1);
    chk("R2 no acknowledge for NMI", ack_req_o, 0);

    nmi_pulse(); nmi_pulse(); repeat (3) step();
    bnd();
    chk("R7 NMI blocked in service", take_o, 0);
    do_iret();
    chk("R8 return ends NMI service", nmi_active_o, 0);
    bnd();
    chk("R7 kept NMI replayed after return", take_o, 1);
    chk("R7 replay is NMI", take_nmi_o, 1);
    do_iret();
    bnd();
    chk("R7 only one NMI kept", take_o, 0);

    wr_ie(1);
    nmi_pulse(); repeat (3) step();
    intr_i = 1; bnd();
    chk("R6 NMI wins over maskable", take_nmi_o, 1);
    chk("R6 no acknowledge started", ack_req_o, 0);
    intr_i = 0; do_iret();

    nmi_i = 1; repeat (5) step();
    bnd();
    chk("R10 held level taken once", take_o, 1);
    do_iret();
    repeat (4) begin bnd(); chk("R10 held level not repeated", take_o, 0); end
    nmi_i = 0;

    wr_ie(1);
    intr_i = 1; bnd();
    ack_vld_i = 1; ack_vec_i = 8'h20; step(); ack_vld_i = 0;
    wr_ie(1);
    bnd();
    chk("R9 nested maskable request", ack_req_o, 1);
    ack_vld_i = 1; ack_vec_i = 8'h21; step(); ack_vld_i = 0; intr_i = 0;
    chk("R9 nested vector", take_vec_o, 8'h21);
    iret_i = 1; ie_wr_i = 1; ie_wdata_i = 0; step();
    iret_i = 0; ie_wr_i = 0;
    chk("R11 return wins over software write", ie_o, 1);
    intr_i = 1; boundary_i = 1; iret_i = 1; ie_wr_i = 1; ie_wdata_i = 1; step();
    boundary_i = 0; iret_i = 0; ie_wr_i = 0; intr_i = 0;
    chk("R11 entry wins over return and write", ie_o, 0);
    ack_vld_i = 1; step(); ack_vld_i = 0;

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) nmi_i = ~nmi_i;
      intr_i     = ($urandom_range(0, 3) != 0);
      boundary_i = ($urandom_range(0, 2) == 0);
      iret_i     = ($urandom_range(0, 19) == 0);
      ie_wr_i    = ($urandom_range(0, 15) == 0);
      ie_wdata_i = $urandom_range(0, 1);
      ack_vld_i  = ack_req_o && ($urandom_range(0, 1) == 1);
      ack_vec_i  = 8'($urandom_range(0, 255));
      step();
    end
    {intr_i, nmi_i, boundary_i, iret_i, ie_wr_i, ack_vld_i} = '0;
    step(); step();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule